// File: doc/BRIEF.md
# Power Register Access Request Packer

This block sits between a requester and a command mailbox that fronts a power-management controller. A requester hands it one list of register accesses: an operation (write, read or read-modify-write), an entry count, up to five 16-bit register addresses and up to five data bytes. The block lays those out as a byte payload and stores the payload as 32-bit words in the mailbox write buffer. It then writes a command word that carries the payload length and the operation.

After the command word goes out, the block reads the mailbox status word repeatedly until the busy flag drops. If busy stays set for a programmable number of reads, the request ends with a timeout. For a read that ends cleanly, the block fetches the read buffer and returns one byte per requested register. The requester sees a one-cycle `rsp_done` pulse and a 2-bit result code. Only one request is in flight at a time, and `req_start` is not acted on while one is running.

The control is a single state machine. Its states are:

- ST_IDLE: waits for a start.
- ST_WRBUF: writes one payload word per cycle.
- ST_CMD: writes the command word.
- ST_POLL_REQ: issues a status read.
- ST_POLL_WAIT: judges the status word that comes back.
- ST_FETCH_REQ: issues a read-buffer read.
- ST_FETCH_WAIT: captures the read-buffer word.
- ST_DONE: pulses done for one cycle.

Its transitions are:

- ST_IDLE to ST_WRBUF on an accepted start.
- ST_IDLE to ST_DONE on a rejected start.
- ST_WRBUF to itself until the last word, then to ST_CMD.
- ST_CMD to ST_POLL_REQ.
- ST_POLL_REQ to ST_POLL_WAIT.
- ST_POLL_WAIT to ST_POLL_REQ while busy and under the limit.
- ST_POLL_WAIT to ST_DONE on a timeout, on a device error, or on clean completion of a write or read-modify-write.
- ST_POLL_WAIT to ST_FETCH_REQ on clean completion of a read.
- ST_FETCH_REQ to ST_FETCH_WAIT.
- ST_FETCH_WAIT to ST_FETCH_REQ until the last word, then to ST_DONE.
- ST_DONE to ST_IDLE.

Top module: `pwr_reg_access`

## Requirements
- R1: After reset, `rsp_done`, `mb_wr_en` and `mb_rd_en` are low, `rsp_err` is 0 and `rsp_rdata` is all zero.
- R2: The command word is written to mailbox offset 0x00. Its layout is:
  - bits 7:0 hold 0xFF;
  - bits 11:8 are zero;
  - bits 15:12 hold the operation id (0 write, 1 read, 2 read-modify-write);
  - bits 23:16 hold the payload size in bytes;
  - bits 31:24 are zero.
- R3: For a read (`req_op`=1), payload byte 2i is the low byte of address i and byte 2i+1 is its high byte. The size is 2 × count.
- R4: For a write (`req_op`=0), the address bytes are laid out as in a read. Data byte i follows at payload byte 2 × count + i, and the size is 3 × count.
- R5: A read-modify-write (`req_op`=2) accesses one register. Its payload is, in order: address low byte, address high byte, data entry 0 (new bits), data entry 1 (mask, 1 = modify). The size is 4.
- R6: The payload is split into ceil(size/4) little-endian words. Word k goes to offset 0x80+4k, and bytes past the size in the last word are zero. Every payload write comes before the command write, and the block never reads and writes the mailbox in the same cycle.
- R7: Some starts are rejected: a count of 0 or above 5, `req_op`=3, or a read-modify-write with a count other than 1. A rejected start pulses `rsp_done` in the next cycle with `rsp_err`=1 and makes no mailbox access.
- R8: After the command write, the status word at offset 0x04 is read repeatedly, and bit 0 is busy. If `POLL_LIMIT` reads in a row all show busy, the request ends with `rsp_err`=2 and no further mailbox access.
- R9: If status bit 1 is set in the first status word that shows busy clear, the request ends with `rsp_err`=3 and the read buffer is not fetched.
- R10: When a read ends without error, the read-buffer words at 0x90+4k are fetched for k < ceil(count/4). `rsp_rdata` byte n equals read-buffer byte n for n < count and is zero above that, and `rsp_err` is 0.
- R11: `rsp_done` is a one-cycle pulse ending each request. A `req_start` seen while a request is running, including the cycle `rsp_done` is high, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start a request (acted on only when idle) |
| req_op | input | 2 | Operation: 0 write, 1 read, 2 read-modify-write, 3 reserved |
| req_count | input | CNT_W (3) | Number of entries |
| req_addrs | input | 16×MAX_ENT | Register addresses; entry i at bits 16i+15:16i |
| req_data | input | 8×MAX_ENT | Data bytes; entry i at bits 8i+7:8i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | 0 ok, 1 bad request, 2 timeout, 3 device error |
| rsp_rdata | output | 8×MAX_ENT | Read results; byte n at bits 8n+7:8n |
| mb_wr_en | output | 1 | Mailbox write strobe |
| mb_wr_ofs | output | 8 | Mailbox write byte offset |
| mb_wr_word | output | 32 | Mailbox write data |
| mb_rd_en | output | 1 | Mailbox read strobe |
| mb_rd_ofs | output | 8 | Mailbox read byte offset |
| mb_rd_word | input | 32 | Mailbox read data, valid the cycle after `mb_rd_en` |

## Verification
Two functions can decide the same status word: the busy flag clearing and the poll counter reaching its limit. The bench provokes this by holding the mailbox busy for exactly `POLL_LIMIT`−1 reads and then for exactly `POLL_LIMIT` reads. The first case must end cleanly after `POLL_LIMIT` status reads, and the second must end in a timeout with the same number of reads. A second collision is a new start arriving in the very cycle `rsp_done` is high. The bench holds `req_start` high across a whole request with changed operands and checks that no second request begins.

// File: rtl/pra_pkg.sv
package pra_pkg;

    localparam int PRA_ADDR_W = 16;
    localparam int PRA_DATA_W = 8;
    localparam int PRA_WORD_W = 32;

    localparam logic [7:0] PRA_CMD_CODE = 8'hFF;

    localparam logic [7:0] MB_CMD_OFS  = 8'h00;
    localparam logic [7:0] MB_STAT_OFS = 8'h04;
    localparam logic [7:0] MB_WBUF_OFS = 8'h80;
    localparam logic [7:0] MB_RBUF_OFS = 8'h90;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RMW   = 2'd2,
        OP_RSVD  = 2'd3
    } pra_op_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ARG     = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_DEVICE  = 2'd3
    } pra_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRBUF,
        ST_CMD,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_DONE
    } pra_state_e;

endpackage

// File: rtl/pra_pack.sv
module pra_pack
    import pra_pkg::*;
#(
    parameter int MAX_ENT   = 5,
    parameter int CNT_W     = 3,
    parameter int MAX_WORDS = 4,
    parameter int WCNT_W    = 3
) (
    input  pra_op_e                          op,
    input  logic [CNT_W-1:0]                 count,
    input  logic [MAX_ENT*PRA_ADDR_W-1:0]    addrs,
    input  logic [MAX_ENT*PRA_DATA_W-1:0]    data,
    output logic [MAX_WORDS*PRA_WORD_W-1:0]  words,
    output logic [WCNT_W-1:0]                n_words,
    output logic [PRA_WORD_W-1:0]            cmd_word
);

    localparam int MAX_BYTES = MAX_WORDS * 4;
    localparam int MASK_IDX  = (MAX_ENT > 1) ? 1 : 0;

    int         cnt_i;
    logic [7:0] size;

    always_comb begin
        cnt_i = int'(count);
    end

    // One lane per payload byte position
    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_lane
        localparam int AIDX = ((j / 2) < MAX_ENT) ? (j / 2) : 0;
        localparam int AOFS = AIDX * PRA_ADDR_W + (j % 2) * 8;
        logic [7:0] lane;

        always_comb begin
            int didx;
            lane = '0;
            didx = j - 2 * cnt_i;
            if (op == OP_RMW) begin
                if (j < 2) begin
                    lane = addrs[AOFS +: 8];
                end else if (j == 2) begin
                    lane = data[7:0];
                end else if (j == 3) begin
                    lane = data[MASK_IDX*8 +: 8];
                end
            end else if (j < 2 * cnt_i) begin
                lane = addrs[AOFS +: 8];
            end else if (op == OP_WRITE && j < 3 * cnt_i && didx >= 0 && didx < MAX_ENT) begin
                lane = data[didx*8 +: 8];
            end
        end

        assign words[j*8 +: 8] = lane;
    end

    always_comb begin
        unique case (op)
            OP_READ:  size = 8'(2 * cnt_i);
            OP_WRITE: size = 8'(3 * cnt_i);
            OP_RMW:   size = 8'd4;
            default:  size = 8'd0;
        endcase
    end

    assign n_words  = WCNT_W'((int'(size) + 3) / 4);
    assign cmd_word = {8'h00, size, {2'b00, op}, 4'h0, PRA_CMD_CODE};

endmodule

// File: rtl/pra_poll_timer.sv
module pra_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);

    localparam int PW = $clog2(LIMIT + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    // True while judging the LIMIT-th busy status word
    assign at_limit = (cnt_q == PW'(LIMIT - 1));

endmodule

// File: rtl/pra_unpack.sv
module pra_unpack
    import pra_pkg::*;
#(
    parameter int MAX_ENT = 5,
    parameter int CNT_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          load,
    input  logic [IDX_W-1:0]              widx,
    input  logic [PRA_WORD_W-1:0]         word,
    input  logic [CNT_W-1:0]              count,
    output logic [MAX_ENT*PRA_DATA_W-1:0] bytes
);

    for (genvar n = 0; n < MAX_ENT; n++) begin : g_byte
        logic [7:0] b_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (clear) begin
                b_q <= '0;
            end else if (load && widx == IDX_W'(n / 4) && int'(count) > n) begin
                b_q <= word[(n % 4)*8 +: 8];
            end
        end

        assign bytes[n*8 +: 8] = b_q;
    end

endmodule

// File: rtl/pwr_reg_access.sv
module pwr_reg_access
    import pra_pkg::*;
#(
    parameter int MAX_ENT    = 5,
    parameter int POLL_LIMIT = 100000,
    localparam int CNT_W     = $clog2(MAX_ENT + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_start,
    input  logic [1:0]                    req_op,
    input  logic [CNT_W-1:0]              req_count,
    input  logic [MAX_ENT*PRA_ADDR_W-1:0] req_addrs,
    input  logic [MAX_ENT*PRA_DATA_W-1:0] req_data,
    output logic                          rsp_done,
    output logic [1:0]                    rsp_err,
    output logic [MAX_ENT*PRA_DATA_W-1:0] rsp_rdata,
    output logic                          mb_wr_en,
    output logic [7:0]                    mb_wr_ofs,
    output logic [PRA_WORD_W-1:0]         mb_wr_word,
    output logic                          mb_rd_en,
    output logic [7:0]                    mb_rd_ofs,
    input  logic [PRA_WORD_W-1:0]         mb_rd_word
);

    localparam int MAX_WORDS = (3 * MAX_ENT + 3) / 4;
    localparam int IDX_W     = $clog2(MAX_WORDS + 1);

    pra_state_e                    state_q, state_d;
    pra_op_e                       op_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [MAX_ENT*PRA_ADDR_W-1:0] addrs_q;
    logic [MAX_ENT*PRA_DATA_W-1:0] data_q;
    logic [IDX_W-1:0]              widx_q;
    pra_err_e                      err_q;

    logic [MAX_WORDS*PRA_WORD_W-1:0] pay_words;
    logic [IDX_W-1:0]                n_words;
    logic [IDX_W-1:0]                rd_words;
    logic [PRA_WORD_W-1:0]           cmd_word;
    logic                            req_ok;
    logic                            stat_busy, stat_err;
    logic                            at_limit;
    logic                            last_wr_word, last_rd_word;

    // Request screening
    always_comb begin
        req_ok = (req_count != '0) && (int'(req_count) <= MAX_ENT) && (pra_op_e'(req_op) != OP_RSVD);
        if (pra_op_e'(req_op) == OP_RMW && req_count != CNT_W'(1)) begin
            req_ok = 1'b0;
        end
    end

    pra_pack #(
        .MAX_ENT   (MAX_ENT),
        .CNT_W     (CNT_W),
        .MAX_WORDS (MAX_WORDS),
        .WCNT_W    (IDX_W)
    ) u_pack (
        .op       (op_q),
        .count    (cnt_q),
        .addrs    (addrs_q),
        .data     (data_q),
        .words    (pay_words),
        .n_words  (n_words),
        .cmd_word (cmd_word)
    );

    assign stat_busy    = mb_rd_word[STAT_BUSY_BIT];
    assign stat_err     = mb_rd_word[STAT_ERR_BIT];
    assign rd_words     = IDX_W'((int'(cnt_q) + 3) / 4);
    assign last_wr_word = ((widx_q + IDX_W'(1)) == n_words);
    assign last_rd_word = ((widx_q + IDX_W'(1)) == rd_words);

    pra_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_CMD),
        .step     (state_q == ST_POLL_WAIT && stat_busy && !at_limit),
        .at_limit (at_limit)
    );

    pra_unpack #(
        .MAX_ENT (MAX_ENT),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE && req_start),
        .load  (state_q == ST_FETCH_WAIT),
        .widx  (widx_q),
        .word  (mb_rd_word),
        .count (cnt_q),
        .bytes (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) begin
                    state_d = req_ok ? ST_WRBUF : ST_DONE;
                end
            end
            ST_WRBUF: begin
                if (last_wr_word) begin
                    state_d = ST_CMD;
                end
            end
            ST_CMD:      state_d = ST_POLL_REQ;
            ST_POLL_REQ: state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (stat_busy) begin
                    state_d = at_limit ? ST_DONE : ST_POLL_REQ;
                end else if (stat_err) begin
                    state_d = ST_DONE;
                end else if (op_q == OP_READ) begin
                    state_d = ST_FETCH_REQ;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_FETCH_REQ: state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: begin
                state_d = last_rd_word ? ST_DONE : ST_FETCH_REQ;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request registers, word index and result code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_WRITE;
            cnt_q   <= '0;
            addrs_q <= '0;
            data_q  <= '0;
            widx_q  <= '0;
            err_q   <= ERR_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_start) begin
                        op_q    <= pra_op_e'(req_op);
                        cnt_q   <= req_count;
                        addrs_q <= req_addrs;
                        data_q  <= req_data;
                        widx_q  <= '0;
                        err_q   <= req_ok ? ERR_NONE : ERR_ARG;
                    end
                end
                ST_WRBUF: begin
                    widx_q <= last_wr_word ? '0 : widx_q + IDX_W'(1);
                end
                ST_POLL_WAIT: begin
                    if (stat_busy && at_limit) begin
                        err_q <= ERR_TIMEOUT;
                    end else if (!stat_busy && stat_err) begin
                        err_q <= ERR_DEVICE;
                    end
                    widx_q <= '0;
                end
                ST_FETCH_WAIT: begin
                    widx_q <= widx_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mb_wr_en   = 1'b0;
        mb_wr_ofs  = MB_CMD_OFS;
        mb_wr_word = '0;
        mb_rd_en   = 1'b0;
        mb_rd_ofs  = MB_STAT_OFS;
        rsp_done   = 1'b0;
        unique case (state_q)
            ST_WRBUF: begin
                mb_wr_en   = 1'b1;
                mb_wr_ofs  = MB_WBUF_OFS + 8'({widx_q, 2'b00});
                mb_wr_word = pay_words[widx_q*PRA_WORD_W +: PRA_WORD_W];
            end
            ST_CMD: begin
                mb_wr_en   = 1'b1;
                mb_wr_ofs  = MB_CMD_OFS;
                mb_wr_word = cmd_word;
            end
            ST_POLL_REQ: begin
                mb_rd_en  = 1'b1;
                mb_rd_ofs = MB_STAT_OFS;
            end
            ST_FETCH_REQ: begin
                mb_rd_en  = 1'b1;
                mb_rd_ofs = MB_RBUF_OFS + 8'({widx_q, 2'b00});
            end
            ST_DONE: rsp_done = 1'b1;
            default: ;
        endcase
    end

    assign rsp_err = err_q;

endmodule

// File: rtl/pra_checker.sv
module pra_checker
    import pra_pkg::*;
#(
    parameter int MAX_ENT = 5,
    parameter int CNT_W   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_start,
    input logic [CNT_W-1:0]      req_count,
    input logic                  rsp_done,
    input logic [1:0]            rsp_err,
    input logic                  mb_wr_en,
    input logic [7:0]            mb_wr_ofs,
    input logic [PRA_WORD_W-1:0] mb_wr_word,
    input logic                  mb_rd_en
);

    // Tracks an accepted request from the ports alone
    logic active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (req_start && !active_q) begin
            active_q <= 1'b1;
        end else if (rsp_done) begin
            active_q <= 1'b0;
        end
    end

    p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_wr_en && mb_rd_en));

    p_cmd_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr_en && mb_wr_ofs == MB_CMD_OFS) |->
        (mb_wr_word[7:0] == PRA_CMD_CODE && mb_wr_word[11:8] == 4'h0 &&
         mb_wr_word[31:24] == 8'h00 && mb_wr_word[15:14] == 2'b00));

    p_rmw_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr_en && mb_wr_ofs == MB_CMD_OFS && mb_wr_word[13:12] == 2'd2) |->
        (mb_wr_word[23:16] == 8'd4));

    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !active_q && (req_count == '0 || int'(req_count) > MAX_ENT)) |=>
        (rsp_done && rsp_err == ERR_ARG && !mb_wr_en && !mb_rd_en));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (!mb_wr_en && !mb_rd_en && !rsp_done));

endmodule

bind pwr_reg_access pra_checker #(
    .MAX_ENT (MAX_ENT),
    .CNT_W   (CNT_W)
) u_pra_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_count  (req_count),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .mb_wr_en   (mb_wr_en),
    .mb_wr_ofs  (mb_wr_ofs),
    .mb_wr_word (mb_wr_word),
    .mb_rd_en   (mb_rd_en)
);

// File: tb/tb_pwr_reg_access.sv
module tb_pwr_reg_access;
    import pra_pkg::*;

    localparam int ME  = 5;
    localparam int LIM = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [1:0]    req_op = '0;
    logic [2:0]    req_count = '0;
    logic [79:0]   req_addrs = '0;
    logic [39:0]   req_data = '0;
    logic          rsp_done;
    logic [1:0]    rsp_err;
    logic [39:0]   rsp_rdata;
    logic          mb_wr_en;
    logic [7:0]    mb_wr_ofs;
    logic [31:0]   mb_wr_word;
    logic          mb_rd_en;
    logic [7:0]    mb_rd_ofs;
    logic [31:0]   mb_rd_word = '0;

    pwr_reg_access #(.MAX_ENT(ME), .POLL_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
        .req_count(req_count), .req_addrs(req_addrs), .req_data(req_data),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mb_wr_en(mb_wr_en), .mb_wr_ofs(mb_wr_ofs), .mb_wr_word(mb_wr_word),
        .mb_rd_en(mb_rd_en), .mb_rd_ofs(mb_rd_ofs), .mb_rd_word(mb_rd_word)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    // Mailbox model state
    logic [31:0] wb_word [0:3];
    logic [31:0] cmd_seen = '0;
    int n_pay = 0, n_cmd = 0, n_stat = 0, n_rbuf = 0;
    int last_pay_cyc = 0, last_cmd_cyc = 0;
    int busy_left = 0, busy_cfg = 0;
    bit err_cfg = 0;
    logic [7:0] salt = 8'h00;
    logic [15:0] ad [0:4];
    logic [7:0]  dd [0:4];

    function automatic logic [7:0] rb_byte(int n);
        return 8'(n * 29 + 60) ^ salt;
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mb_wr_en) begin
            if (mb_wr_ofs >= 8'h80 && mb_wr_ofs < 8'h90) begin
                wb_word[(mb_wr_ofs - 8'h80) >> 2] <= mb_wr_word;
                n_pay = n_pay + 1;
                last_pay_cyc = cyc;
            end else if (mb_wr_ofs == 8'h00) begin
                cmd_seen <= mb_wr_word;
                n_cmd = n_cmd + 1;
                last_cmd_cyc = cyc;
                busy_left = busy_cfg;
            end
        end
        if (mb_rd_en) begin
            if (mb_rd_ofs == 8'h04) begin
                n_stat = n_stat + 1;
                mb_rd_word <= {30'b0, (busy_left == 0) && err_cfg, busy_left != 0};
                if (busy_left > 0) busy_left = busy_left - 1;
            end else begin
                int k;
                k = (int'(mb_rd_ofs) - 'h90) / 4;
                n_rbuf = n_rbuf + 1;
                mb_rd_word <= {rb_byte(4*k+3), rb_byte(4*k+2), rb_byte(4*k+1), rb_byte(4*k)};
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input int op, input int cnt, input int busy, input bit errb, input bit hold);
        int p0, c0, s0, r0, waitc, size, nw, experr, exprb;
        bit valid;
        logic [7:0] eb [0:15];
        string ptag;
        busy_cfg = busy;
        err_cfg  = errb;
        p0 = n_pay; c0 = n_cmd; s0 = n_stat; r0 = n_rbuf;
        req_op = 2'(op);
        req_count = 3'(cnt);
        for (int i = 0; i < ME; i++) begin
            req_addrs[i*16 +: 16] = ad[i];
            req_data[i*8 +: 8]    = dd[i];
        end
        req_start = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_op = 2'd1;
            req_count = 3'd2;
        end else begin
            req_start = 1'b0;
        end
        waitc = 0;
        while (!rsp_done && waitc < 500) begin
            @(negedge clk);
            waitc++;
        end
        req_start = 1'b0;
        chk("R11 done pulse seen", 64'(rsp_done), 64'd1);

        valid = cnt >= 1 && cnt <= ME && op != 3 && !(op == 2 && cnt != 1);
        if (!valid)            experr = 1;
        else if (busy >= LIM)  experr = 2;
        else if (errb)         experr = 3;
        else                   experr = 0;

        for (int b = 0; b < 16; b++) eb[b] = 8'h00;
        if (op == 2) begin
            eb[0] = ad[0][7:0]; eb[1] = ad[0][15:8]; eb[2] = dd[0]; eb[3] = dd[1];
            size = 4;
            ptag = "R5";
        end else begin
            for (int i = 0; i < cnt && i < ME; i++) begin
                eb[2*i]   = ad[i][7:0];
                eb[2*i+1] = ad[i][15:8];
            end
            if (op == 0) begin
                for (int i = 0; i < cnt && i < ME; i++) eb[2*cnt+i] = dd[i];
            end
            size = (op == 1) ? 2*cnt : 3*cnt;
            ptag = (op == 1) ? "R3" : "R4";
        end
        nw = (size + 3) / 4;

        chk($sformatf("R7 R8 R9 result code op=%0d cnt=%0d busy=%0d", op, cnt, busy),
            64'(rsp_err), 64'(experr));
        if (!valid) begin
            chk("R7 no mailbox write on reject", 64'(n_pay + n_cmd - p0 - c0), 64'd0);
            chk("R7 no mailbox read on reject", 64'(n_stat + n_rbuf - s0 - r0), 64'd0);
        end else begin
            chk($sformatf("R2 %s command word", ptag), 64'(cmd_seen),
                64'({8'h00, 8'(size), 4'(op), 4'h0, 8'hFF}));
            chk("R6 payload word count", 64'(n_pay - p0), 64'(nw));
            chk("R6 command after payload", 64'(last_cmd_cyc > last_pay_cyc), 64'd1);
            for (int k = 0; k < nw; k++) begin
                chk($sformatf("%s R6 payload word %0d", ptag, k), 64'(wb_word[k]),
                    64'({eb[4*k+3], eb[4*k+2], eb[4*k+1], eb[4*k]}));
            end
            chk("R8 status read count", 64'(n_stat - s0), 64'((busy >= LIM) ? LIM : busy + 1));
        end
        exprb = (experr == 0 && op == 1) ? (cnt + 3) / 4 : 0;
        chk("R9 R10 read buffer fetches", 64'(n_rbuf - r0), 64'(exprb));
        for (int n = 0; n < ME; n++) begin
            chk($sformatf("R10 result byte %0d", n), 64'(rsp_rdata[n*8 +: 8]),
                64'((experr == 0 && op == 1 && n < cnt) ? rb_byte(n) : 8'h00));
        end
        @(negedge clk);
        chk("R11 done lasts one cycle", 64'(rsp_done), 64'd0);
        if (hold) begin
            p0 = n_pay + n_cmd + n_stat + n_rbuf;
            repeat (4) @(negedge clk);
            chk("R11 start during request ignored", 64'(n_pay + n_cmd + n_stat + n_rbuf - p0), 64'd0);
            chk("R11 no second done", 64'(rsp_done), 64'd0);
        end
    endtask

    task automatic set_ops(input int seed);
        for (int i = 0; i < ME; i++) begin
            ad[i] = 16'(16'h1234 * (seed + 1) + i * 16'h0111);
            dd[i] = 8'(8'h5A + seed * 17 + i * 43);
        end
        salt = 8'(seed * 71);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual=%0d expected<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) wb_word[k] = '0;
        set_ops(0);
        repeat (3) @(negedge clk);
        chk("R1 done low in reset", 64'(rsp_done), 64'd0);
        chk("R1 no access in reset", 64'({mb_wr_en, mb_rd_en}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 result code after reset", 64'(rsp_err), 64'd0);
        chk("R1 result bytes after reset", 64'(rsp_rdata), 64'd0);
        chk("R1 quiet after reset", 64'({rsp_done, mb_wr_en, mb_rd_en}), 64'd0);

        // Sweep writes and reads over every legal count
        for (int seed = 0; seed < 3; seed++) begin
            for (int op = 0; op < 2; op++) begin
                for (int cnt = 1; cnt <= ME; cnt++) begin
                    set_ops(seed * 7 + cnt);
                    run_req(op, cnt, seed, 1'b0, 1'b0);
                end
            end
        end
        // Read-modify-write
        for (int seed = 0; seed < 4; seed++) begin
            set_ops(40 + seed);
            run_req(2, 1, seed, 1'b0, 1'b0);
        end
        // Rejected requests
        set_ops(50);
        run_req(0, 0, 0, 1'b0, 1'b0);
        run_req(1, 6, 0, 1'b0, 1'b0);
        run_req(0, 7, 0, 1'b0, 1'b0);
        run_req(3, 2, 0, 1'b0, 1'b0);
        run_req(2, 2, 0, 1'b0, 1'b0);
        run_req(2, 0, 0, 1'b0, 1'b0);
        // Busy clears on the last allowed poll versus timeout
        set_ops(60);
        run_req(1, 3, LIM - 1, 1'b0, 1'b0);
        run_req(1, 3, LIM, 1'b0, 1'b0);
        run_req(0, 2, LIM - 1, 1'b0, 1'b0);
        run_req(0, 2, LIM + 3, 1'b0, 1'b0);
        run_req(2, 1, LIM, 1'b0, 1'b0);
        // Device error
        set_ops(70);
        run_req(1, 5, 2, 1'b1, 1'b0);
        run_req(0, 4, 0, 1'b1, 1'b0);
        run_req(1, 4, LIM, 1'b1, 1'b0);
        // Start held through the request and its done cycle
        set_ops(80);
        run_req(1, 5, 1, 1'b0, 1'b1);
        set_ops(81);
        run_req(0, 3, 0, 1'b0, 1'b1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule